// File: doc/BRIEF.md
# Decimating Filter Control Registers and Start Sequencer

This block is the configuration front end of a two-stage decimating filter. A host writes 16-bit words over a write-only bus qualified by an active-low chip select, an active-low write strobe and a 2-bit address. The strobe is sampled in the block's clock domain, and each rising edge of the strobe commits one word. Three addresses hold configuration fields: tap count, decimation factors, symmetry, bypass selects, clear-accumulator, FIR disable, stage count and growth shift. The fourth address is a coefficient port. Each 20-bit coefficient takes two bus writes. The assembled word is presented on a memory write port, and the address on that port advances by one for each coefficient.

A start sequencer holds the filter idle until it sees a start event. The asynchronous start request passes through a two-flop synchronizer. A falling edge on the synchronized signal drives a one-cycle start-out pulse, which can start further devices in a chain. The synchronous start input is edge-detected directly. Either event moves the sequencer from `SQ_IDLE` to `SQ_RUN` and clears the FIR disable bit. Only reset returns the sequencer to `SQ_IDLE`.

The coefficient assembler is a two-state machine. In `CF_HI_WAIT`, a coefficient write is taken as the upper sixteen bits and moves the machine to `CF_LO_WAIT`. In `CF_LO_WAIT`, a coefficient write completes the word, issues the memory write and moves the machine back to `CF_HI_WAIT`. A rewind returns the machine to `CF_HI_WAIT` from either state.

Top module: `decim_ctrl`

## Requirements
- R1: A register is updated only by a rising edge of `wr_n` during which `cs_n` was low. A strobe with `cs_n` high changes nothing, and a strobe held low changes nothing until it rises.
- R2: Address 0 layout: bits 8:0 `fir_taps`, bits 12:9 `fir_drate`, bit 13 `fir_even_sym`, bit 14 `fir_bypass`, bit 15 `fir_zero_pre`.
- R3: Address 2 layout: bits 9:0 `fe_drate`, bit 10 `fe_bypass`, bit 11 `fir_clr_acc`, bit 12 `fir_disable`. Address 3 layout: bits 2:0 `fe_stages`, bits 8:3 `fe_growth`.
- R4: Coefficient writes go to address 1. The first write supplies coefficient bits 19:4. The second write supplies bits 3:0 in data bits 3:0. The second write raises `coef_we` for exactly one cycle, with `coef_data` set to the assembled word and `coef_addr` set to a pointer that starts at 0 and increments by one per coefficient. The first write raises no `coef_we`.
- R5: While `rst` is high and after it is released, `fir_bypass`, `fe_stages` and `fe_drate` read 0, `fir_disable` reads 1, and the coefficient pointer is 0.
- R6: A write to address 2 with bit 12 set rewinds the coefficient pointer to 0 and discards a pending upper half.
- R7: A falling edge on `astart_n` raises `start_out` for exactly one cycle. The pulse appears after the third rising clock edge that samples `astart_n` low, and `run_en` rises on that same edge.
- R8: A high-to-low transition of `start_n` between two sampling edges raises `run_en` on the next rising edge.
- R9: A start input that is low from reset onward, with no high-to-low transition, never raises `run_en`.
- R10: Once `run_en` is high, it stays high until reset. Any start event clears `fir_disable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; commits on rising edge |
| addr | input | 2 | Register select |
| cbus | input | 16 | Write data |
| astart_n | input | 1 | Asynchronous start request, falling-edge active |
| start_n | input | 1 | Synchronous start, falling-edge active |
| start_out | output | 1 | One-cycle start pulse for chained devices |
| run_en | output | 1 | Internal run enable |
| fir_taps | output | 9 | Tap count minus one |
| fir_drate | output | 4 | FIR decimation minus one |
| fir_even_sym | output | 1 | Even symmetry select |
| fir_bypass | output | 1 | FIR bypass |
| fir_zero_pre | output | 1 | Zero one pre-adder input |
| fe_drate | output | 10 | Front-end decimation minus one |
| fe_bypass | output | 1 | Front-end bypass |
| fir_clr_acc | output | 1 | Clear accumulator feedback |
| fir_disable | output | 1 | FIR disable |
| fe_stages | output | 3 | Front-end stage count |
| fe_growth | output | 6 | Growth shift value |
| coef_we | output | 1 | Coefficient memory write enable |
| coef_addr | output | 9 | Coefficient memory address |
| coef_data | output | 20 | Coefficient memory data |

## Verification
A register write becomes visible after the second rising clock edge that follows the strobe's rising edge. The first of these edges detects the strobe edge and the second loads the field. The bench therefore samples fields only after waiting several falling edges from the strobe release. It watches `coef_we` on each of the four falling edges after the release, so that it can count pulses rather than assume one. For `astart_n`, `start_out` and `run_en` are due after the third sampling edge, and the bench checks every falling edge from the first to the fourth. For `start_n`, `run_en` is due one edge after the low level is sampled, and the bench checks the edge before it as well as the edge at which it is due.

// File: rtl/decim_ctrl_pkg.sv
package decim_ctrl_pkg;
    localparam int BUS_W   = 16;
    localparam int TAP_W   = 9;
    localparam int FDEC_W  = 4;
    localparam int HDEC_W  = 10;
    localparam int STG_W   = 3;
    localparam int GRW_W   = 6;
    localparam int COEF_W  = 20;
    localparam int CADDR_W = 9;
    localparam int LO_W    = COEF_W - BUS_W;

    // address 0 field positions
    localparam int FDEC_LSB = TAP_W;
    localparam int ESYM_BIT = TAP_W + FDEC_W;
    localparam int FBYP_BIT = ESYM_BIT + 1;
    localparam int ZPRE_BIT = ESYM_BIT + 2;
    // address 2 field positions
    localparam int HBYP_BIT = HDEC_W;
    localparam int CLA_BIT  = HDEC_W + 1;
    localparam int DIS_BIT  = HDEC_W + 2;
    // address 3 field positions
    localparam int GRW_LSB  = STG_W;

    localparam logic [1:0] A_FIR  = 2'd0;
    localparam logic [1:0] A_COEF = 2'd1;
    localparam logic [1:0] A_FEC  = 2'd2;
    localparam logic [1:0] A_FES  = 2'd3;

    typedef enum logic {CF_HI_WAIT, CF_LO_WAIT} coef_state_t;
    typedef enum logic {SQ_IDLE, SQ_RUN} seq_state_t;
endpackage

// File: rtl/decim_ctrl_wrsync.sv
module decim_ctrl_wrsync
    import decim_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] cbus,
    output logic             wr_hit,
    output logic [1:0]       hit_addr,
    output logic [BUS_W-1:0] hit_data
);
    logic             s1_wr, s2_wr, s1_cs, s2_cs;
    logic [1:0]       s1_a, s2_a;
    logic [BUS_W-1:0] s1_d, s2_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            s1_wr <= 1'b1;
            s2_wr <= 1'b1;
            s1_cs <= 1'b1;
            s2_cs <= 1'b1;
            s1_a  <= '0;
            s2_a  <= '0;
            s1_d  <= '0;
            s2_d  <= '0;
        end else begin
            s1_wr <= wr_n;
            s2_wr <= s1_wr;
            s1_cs <= cs_n;
            s2_cs <= s1_cs;
            s1_a  <= addr;
            s2_a  <= s1_a;
            s1_d  <= cbus;
            s2_d  <= s1_d;
        end
    end

    // strobe rose between the two samples; fields come from the low phase
    assign wr_hit   = s1_wr & ~s2_wr & ~s2_cs;
    assign hit_addr = s2_a;
    assign hit_data = s2_d;

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst) wr_hit |=> !wr_hit); // R1
endmodule

// File: rtl/decim_ctrl_regs.sv
module decim_ctrl_regs
    import decim_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_hit,
    input  logic [1:0]         hit_addr,
    input  logic [BUS_W-1:0]   hit_data,
    input  logic               go,
    output logic [TAP_W-1:0]   fir_taps,
    output logic [FDEC_W-1:0]  fir_drate,
    output logic               fir_even_sym,
    output logic               fir_bypass,
    output logic               fir_zero_pre,
    output logic [HDEC_W-1:0]  fe_drate,
    output logic               fe_bypass,
    output logic               fir_clr_acc,
    output logic               fir_disable,
    output logic [STG_W-1:0]   fe_stages,
    output logic [GRW_W-1:0]   fe_growth,
    output logic               coef_we,
    output logic [CADDR_W-1:0] coef_addr,
    output logic [COEF_W-1:0]  coef_data
);
    coef_state_t        cst, cst_n;
    logic [CADDR_W-1:0] ptr;
    logic [BUS_W-1:0]   hi_q;
    logic               coef_hit, rewind;

    assign coef_hit = wr_hit && (hit_addr == A_COEF);
    assign rewind   = wr_hit && (hit_addr == A_FEC) && hit_data[DIS_BIT];

    // configuration fields
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            fir_taps     <= '0;
            fir_drate    <= '0;
            fir_even_sym <= 1'b0;
            fir_bypass   <= 1'b0;
            fir_zero_pre <= 1'b0;
            fe_drate     <= '0;
            fe_bypass    <= 1'b0;
            fir_clr_acc  <= 1'b0;
            fir_disable  <= 1'b1;
            fe_stages    <= '0;
            fe_growth    <= '0;
        end else begin
            if (wr_hit) begin
                unique case (hit_addr)
                    A_FIR: begin
                        fir_taps     <= hit_data[TAP_W-1:0];
                        fir_drate    <= hit_data[FDEC_LSB +: FDEC_W];
                        fir_even_sym <= hit_data[ESYM_BIT];
                        fir_bypass   <= hit_data[FBYP_BIT];
                        fir_zero_pre <= hit_data[ZPRE_BIT];
                    end
                    A_FEC: begin
                        fe_drate    <= hit_data[HDEC_W-1:0];
                        fe_bypass   <= hit_data[HBYP_BIT];
                        fir_clr_acc <= hit_data[CLA_BIT];
                        fir_disable <= hit_data[DIS_BIT];
                    end
                    A_FES: begin
                        fe_stages <= hit_data[STG_W-1:0];
                        fe_growth <= hit_data[GRW_LSB +: GRW_W];
                    end
                    A_COEF: ;
                endcase
            end
            if (go) fir_disable <= 1'b0;
        end
    end

    // coefficient assembler: state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) cst <= CF_HI_WAIT;
        else     cst <= cst_n;
    end

    always_comb begin
        cst_n = cst;
        unique case (cst)
            CF_HI_WAIT: if (coef_hit) cst_n = CF_LO_WAIT;
            CF_LO_WAIT: if (coef_hit) cst_n = CF_HI_WAIT;
        endcase
        if (rewind) cst_n = CF_HI_WAIT;
    end

    // coefficient assembler: outputs and pointer
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ptr       <= '0;
            hi_q      <= '0;
            coef_we   <= 1'b0;
            coef_addr <= '0;
            coef_data <= '0;
        end else begin
            coef_we <= 1'b0;
            if (rewind) begin
                ptr <= '0;
            end else if (coef_hit && cst == CF_HI_WAIT) begin
                hi_q <= hit_data;
            end else if (coef_hit && cst == CF_LO_WAIT) begin
                coef_we   <= 1'b1;
                coef_addr <= ptr;
                coef_data <= {hi_q, hit_data[LO_W-1:0]};
                ptr       <= ptr + 1'b1;
            end
        end
    end

    AST_WE_PULSE:    assert property (@(posedge clk) disable iff (rst) coef_we |=> !coef_we); // R4
    AST_PTR_STEP:    assert property (@(posedge clk) disable iff (rst) coef_we |-> (ptr == coef_addr + 1'b1)); // R4
    AST_REWIND_PTR:  assert property (@(posedge clk) disable iff (rst) rewind |=> (ptr == '0 && cst == CF_HI_WAIT)); // R6
    AST_DIS_CLEARED: assert property (@(posedge clk) disable iff (rst) go |=> !fir_disable); // R10
endmodule

// File: rtl/decim_ctrl_start.sv
module decim_ctrl_start
    import decim_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic astart_n,
    input  logic start_n,
    output logic start_out,
    output logic run_en,
    output logic go
);
    seq_state_t st, st_n;
    logic a1, a2, a3, sn_q, sn_p;
    logic a_fall, s_fall;

    // two-flop synchronizer plus edge stage; reset low so a held-low input never counts
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            a1        <= 1'b0;
            a2        <= 1'b0;
            a3        <= 1'b0;
            sn_q      <= 1'b0;
            sn_p      <= 1'b0;
            start_out <= 1'b0;
        end else begin
            a1        <= astart_n;
            a2        <= a1;
            a3        <= a2;
            sn_q      <= start_n;
            sn_p      <= sn_q;
            start_out <= a_fall;
        end
    end

    assign a_fall = a3 & ~a2;
    assign s_fall = sn_p & ~sn_q;
    assign go     = a_fall | s_fall;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            SQ_IDLE: if (go) st_n = SQ_RUN;
            SQ_RUN:  st_n = SQ_RUN;
        endcase
    end

    assign run_en = (st == SQ_RUN);

    AST_SOUT_WIDTH: assert property (@(posedge clk) disable iff (rst) start_out |=> !start_out); // R7
    AST_RUN_HOLD:   assert property (@(posedge clk) disable iff (rst) run_en |=> run_en); // R10
    AST_RUN_CAUSE:  assert property (@(posedge clk) disable iff (rst) $rose(run_en) |-> $past(go)); // R8
endmodule

// File: rtl/decim_ctrl.sv
module decim_ctrl
    import decim_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic [1:0]         addr,
    input  logic [BUS_W-1:0]   cbus,
    input  logic               astart_n,
    input  logic               start_n,
    output logic               start_out,
    output logic               run_en,
    output logic [TAP_W-1:0]   fir_taps,
    output logic [FDEC_W-1:0]  fir_drate,
    output logic               fir_even_sym,
    output logic               fir_bypass,
    output logic               fir_zero_pre,
    output logic [HDEC_W-1:0]  fe_drate,
    output logic               fe_bypass,
    output logic               fir_clr_acc,
    output logic               fir_disable,
    output logic [STG_W-1:0]   fe_stages,
    output logic [GRW_W-1:0]   fe_growth,
    output logic               coef_we,
    output logic [CADDR_W-1:0] coef_addr,
    output logic [COEF_W-1:0]  coef_data
);
    logic             wr_hit, go;
    logic [1:0]       hit_addr;
    logic [BUS_W-1:0] hit_data;

    decim_ctrl_wrsync u_wrsync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .cbus(cbus),
        .wr_hit(wr_hit), .hit_addr(hit_addr), .hit_data(hit_data)
    );

    decim_ctrl_start u_start (
        .clk(clk), .rst(rst), .astart_n(astart_n), .start_n(start_n),
        .start_out(start_out), .run_en(run_en), .go(go)
    );

    decim_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .hit_addr(hit_addr), .hit_data(hit_data),
        .go(go),
        .fir_taps(fir_taps), .fir_drate(fir_drate), .fir_even_sym(fir_even_sym),
        .fir_bypass(fir_bypass), .fir_zero_pre(fir_zero_pre),
        .fe_drate(fe_drate), .fe_bypass(fe_bypass), .fir_clr_acc(fir_clr_acc),
        .fir_disable(fir_disable), .fe_stages(fe_stages), .fe_growth(fe_growth),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
    );
endmodule

// File: tb/decim_ctrl_tb.sv
module decim_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [15:0] cbus = '0;
    logic        astart_n = 1'b1, start_n = 1'b0;
    logic        start_out, run_en;
    logic [8:0]  fir_taps;
    logic [3:0]  fir_drate;
    logic        fir_even_sym, fir_bypass, fir_zero_pre;
    logic [9:0]  fe_drate;
    logic        fe_bypass, fir_clr_acc, fir_disable;
    logic [2:0]  fe_stages;
    logic [5:0]  fe_growth;
    logic        coef_we;
    logic [8:0]  coef_addr;
    logic [19:0] coef_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    decim_ctrl u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .cbus(cbus),
        .astart_n(astart_n), .start_n(start_n), .start_out(start_out), .run_en(run_en),
        .fir_taps(fir_taps), .fir_drate(fir_drate), .fir_even_sym(fir_even_sym),
        .fir_bypass(fir_bypass), .fir_zero_pre(fir_zero_pre), .fe_drate(fe_drate),
        .fe_bypass(fe_bypass), .fir_clr_acc(fir_clr_acc), .fir_disable(fir_disable),
        .fe_stages(fe_stages), .fe_growth(fe_growth), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_data(coef_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus write; counts coef_we pulses on the four falling edges after release
    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic sel,
                          output int np, output logic [8:0] pa, output logic [19:0] pd);
        np = 0; pa = '0; pd = '0;
        @(negedge clk); cs_n = ~sel; addr = a; cbus = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); cs_n = 1'b1;
            if (coef_we) begin np++; pa = coef_addr; pd = coef_data; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int np;
        logic [8:0]  pa;
        logic [19:0] pd;
        logic [15:0] d;

        repeat (3) @(negedge clk);
        chk("R5 disable during reset", {31'd0, fir_disable}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 fir_bypass", {31'd0, fir_bypass}, 32'd0);
        chk("R5 fe_stages", {29'd0, fe_stages}, 32'd0);
        chk("R5 fe_drate", {22'd0, fe_drate}, 32'd0);
        chk("R5 fir_disable", {31'd0, fir_disable}, 32'd1);
        chk("R5 run_en", {31'd0, run_en}, 32'd0);

        // R9: start_n low from reset without a transition
        repeat (6) @(negedge clk);
        chk("R9 no start on held low", {31'd0, run_en}, 32'd0);

        // R2 sweep
        for (int i = 0; i < 16; i++) begin
            d = 16'(i * 16'h1111) ^ 16'(i << 9) ^ 16'h2a5;
            bus_wr(2'd0, d, 1'b1, np, pa, pd);
            chk("R2 fir_taps", {23'd0, fir_taps}, {23'd0, d[8:0]});
            chk("R2 fir_drate", {28'd0, fir_drate}, {28'd0, d[12:9]});
            chk("R2 flags", {29'd0, fir_zero_pre, fir_bypass, fir_even_sym}, {29'd0, d[15:13]});
        end

        // R3 sweep
        for (int i = 0; i < 16; i++) begin
            d = 16'(i * 16'h0d3b) & 16'h0fff;
            bus_wr(2'd2, d, 1'b1, np, pa, pd);
            chk("R3 fe_drate", {22'd0, fe_drate}, {22'd0, d[9:0]});
            chk("R3 flags", {30'd0, fir_clr_acc, fe_bypass}, {30'd0, d[11:10]});
            d = 16'(i * 16'h0125 + 7);
            bus_wr(2'd3, d, 1'b1, np, pa, pd);
            chk("R3 fe_stages", {29'd0, fe_stages}, {29'd0, d[2:0]});
            chk("R3 fe_growth", {26'd0, fe_growth}, {26'd0, d[8:3]});
        end
        bus_wr(2'd2, 16'h1000, 1'b1, np, pa, pd);
        chk("R3 disable bit", {31'd0, fir_disable}, 32'd1);

        // R1: cs high ignored
        bus_wr(2'd0, 16'h0123, 1'b1, np, pa, pd);
        bus_wr(2'd0, 16'hfedc, 1'b0, np, pa, pd);
        chk("R1 cs high ignored", {23'd0, fir_taps}, 32'h123);
        // R1: no commit while strobe held low
        @(negedge clk); cs_n = 1'b0; addr = 2'd0; cbus = 16'h0055; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 held strobe", {23'd0, fir_taps}, 32'h123);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        chk("R1 commit on rise", {23'd0, fir_taps}, 32'h055);

        // R4 coefficient sequence
        for (int i = 0; i < 12; i++) begin
            logic [19:0] cw;
            cw = 20'(i * 20'h3c5a7 + 20'h00901);
            bus_wr(2'd1, cw[19:4], 1'b1, np, pa, pd);
            chk("R4 no pulse on upper half", np, 32'd0);
            bus_wr(2'd1, {12'habc, cw[3:0]}, 1'b1, np, pa, pd);
            chk("R4 one pulse", np, 32'd1);
            chk("R4 coef_addr", {23'd0, pa}, i);
            chk("R4 coef_data", {12'd0, pd}, {12'd0, cw});
        end

        // R6 rewind discards pending half
        bus_wr(2'd1, 16'hdead, 1'b1, np, pa, pd);
        bus_wr(2'd2, 16'h1000, 1'b1, np, pa, pd);
        bus_wr(2'd1, 16'h1234, 1'b1, np, pa, pd);
        chk("R6 first after rewind is upper", np, 32'd0);
        bus_wr(2'd1, 16'h0005, 1'b1, np, pa, pd);
        chk("R6 pulse", np, 32'd1);
        chk("R6 addr rewound", {23'd0, pa}, 32'd0);
        chk("R6 data", {12'd0, pd}, 32'h12345);

        // R8 synchronous start
        @(negedge clk); start_n = 1'b1;
        repeat (3) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        chk("R8 not yet", {31'd0, run_en}, 32'd0);
        @(negedge clk);
        chk("R8 run_en", {31'd0, run_en}, 32'd1);
        chk("R8 no start_out", {31'd0, start_out}, 32'd0);
        chk("R10 disable cleared", {31'd0, fir_disable}, 32'd0);

        // R10 sticky run
        bus_wr(2'd2, 16'h1000, 1'b1, np, pa, pd);
        start_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 run sticky", {31'd0, run_en}, 32'd1);
        chk("R10 disable set by write", {31'd0, fir_disable}, 32'd1);

        // R7 asynchronous start
        do_reset();
        chk("R5 run cleared by reset", {31'd0, run_en}, 32'd0);
        chk("R5 disable set by reset", {31'd0, fir_disable}, 32'd1);
        repeat (4) @(negedge clk);
        astart_n = 1'b0;
        @(negedge clk);
        chk("R7 edge1", {30'd0, start_out, run_en}, 32'd0);
        @(negedge clk);
        chk("R7 edge2", {30'd0, start_out, run_en}, 32'd0);
        @(negedge clk);
        chk("R7 edge3 pulse and run", {30'd0, start_out, run_en}, 32'd3);
        @(negedge clk);
        chk("R7 edge4 pulse ends", {30'd0, start_out, run_en}, 32'd1);
        chk("R10 async start clears disable", {31'd0, fir_disable}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R7 single pulse", {31'd0, start_out}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule